// File: doc/BRIEF.md
# Click Gesture Detector

This block watches a row of twelve binary click pixels that a sensing front end has already turned into logic levels. At a slice rate picked by a two-bit field, it samples the row once and sorts it by a strong majority into black (finger on the sensor), white (no finger) or undecided. Each change between black and white is a touch transition. When two transitions come close together, the block reports a click: the two transitions are a quick touch and release, or the reverse.

A three-bit field sets the window, measured in slices. A pair of transitions with fewer slices than the window between them is a click. A slower pair is an ordinary finger placement or removal. The click shows as a single-cycle pulse and as a flag that stays set until reset. The slice period comes from the core clock through a divider whose base count is a parameter. The configuration fields are meant to stay unchanged while the enable is high. The intended settings at start-up are rate code 01, threshold code 01 and window code 101.

Top module: `click_detect`

## Requirements
- R1: After a synchronous reset, click_pulse and click_seen are 0.
- R2: While en is high, a slice boundary occurs every BASE_DIV*(rate_sel+1) clock cycles, counted from the first rising edge with en high. Rate codes 00, 01, 10 and 11 give slice rates in the ratio 4:2:(4/3):1. The pixel row is sampled only at a boundary.
- R3: With threshold code k, a slice is black when more than 7+k of the 12 pixels are 1 and fewer than 5-k are 0. It is white when more than 7+k pixels are 0 and fewer than 5-k are 1. Otherwise it is undecided.
- R4: An undecided slice leaves the finger state unchanged. It still counts as one slice of the gap after a pending transition.
- R5: Two transitions form a click when the number of slices strictly between them is less than the window. Window codes 000 through 111 map to 5, 7, 10, 12, 16, 20, 25 and 31 slices.
- R6: The gap count stops at the window length. A transition that comes after a gap at least as long as the window produces no click and opens a new window.
- R7: After a click, tracking restarts. The next transition opens a new window and cannot pair with the transition that completed the click.
- R8: click_pulse is high for exactly the one cycle after the clock edge on which the click's second transition is sampled. click_seen rises in the same cycle and stays 1 until reset.
- R9: While en is low, the divider and the tracking state are cleared and no click is reported. click_seen keeps its value.
- R10: After reset or after en rises, the finger state is white, so a first black slice counts as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Click detection enable |
| pix | input | 12 | Binary click pixel row |
| rate_sel | input | 2 | Slice rate code |
| thr_sel | input | 2 | Majority threshold code |
| win_sel | input | 3 | Click window code |
| click_pulse | output | 1 | One-cycle click indication |
| click_seen | output | 1 | Sticky click flag |

## Verification
A slice boundary falls on the clock edge where the divider reaches its last count. A click decided on that edge appears on click_pulse and click_seen one cycle later, because the tracker registers its result. After every rising edge, the bench steps a behavioural model of the slice timing and the transition rules, then compares both outputs 2 ns later. Inputs change only after that comparison. For each scenario the bench also counts the click pulses and compares the total with a value worked out by hand.

// File: rtl/click_pkg.sv
package click_pkg;

    localparam int NPIX     = 12;
    localparam int ONES_W   = $clog2(NPIX + 1);
    localparam int MAJ_BASE = 7;
    localparam int MIN_BASE = 5;
    localparam int WIN_W    = 5;

    typedef enum logic [1:0] {
        SLC_WHITE = 2'd0,
        SLC_BLACK = 2'd1,
        SLC_UNDEC = 2'd2
    } slice_class_t;

    typedef struct packed {
        logic [1:0] rate;
        logic [1:0] thr;
        logic [2:0] win;
    } click_cfg_t;

    typedef struct packed {
        logic             finger;
        logic             armed;
        logic [WIN_W-1:0] gap;
    } track_t;

    function automatic logic [WIN_W-1:0] window_len(input logic [2:0] code);
        case (code)
            3'd0:    return WIN_W'(5);
            3'd1:    return WIN_W'(7);
            3'd2:    return WIN_W'(10);
            3'd3:    return WIN_W'(12);
            3'd4:    return WIN_W'(16);
            3'd5:    return WIN_W'(20);
            3'd6:    return WIN_W'(25);
            default: return WIN_W'(31);
        endcase
    endfunction

    function automatic logic [ONES_W-1:0] count_ones(input logic [NPIX-1:0] v);
        logic [ONES_W-1:0] n;
        n = '0;
        for (int i = 0; i < NPIX; i++) begin
            n = n + ONES_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/click_slice_timer.sv
module click_slice_timer
    import click_pkg::*;
#(
    parameter int BASE_DIV = 694444
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       slice_tick
);
    localparam int MAX_PERIOD = 4 * BASE_DIV;
    localparam int CW         = $clog2(MAX_PERIOD) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;

    always_comb begin
        last_cnt = CW'(BASE_DIV * (int'(rate_sel) + 1) - 1);
    end

    assign slice_tick = en && (cnt == last_cnt);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (slice_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_cnt); // R2

endmodule

// File: rtl/click_slice_classify.sv
module click_slice_classify
    import click_pkg::*;
(
    input  logic [NPIX-1:0] pix,
    input  logic [1:0]      thr_sel,
    output slice_class_t    cls
);
    logic [ONES_W-1:0] ones;
    logic [ONES_W-1:0] zeros;
    logic [ONES_W-1:0] hi_lim;
    logic [ONES_W-1:0] lo_lim;
    logic              is_black;
    logic              is_white;

    always_comb begin
        ones     = count_ones(pix);
        zeros    = ONES_W'(NPIX) - ones;
        hi_lim   = ONES_W'(MAJ_BASE) + ONES_W'(thr_sel);
        lo_lim   = ONES_W'(MIN_BASE) - ONES_W'(thr_sel);
        is_black = (ones > hi_lim) && (zeros < lo_lim);
        is_white = (zeros > hi_lim) && (ones < lo_lim);
        if (is_black)      cls = SLC_BLACK;
        else if (is_white) cls = SLC_WHITE;
        else               cls = SLC_UNDEC;
    end

endmodule

// File: rtl/click_pair_tracker.sv
module click_pair_tracker
    import click_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         slice_tick,
    input  slice_class_t cls,
    input  logic [2:0]   win_sel,
    output logic         click_pulse,
    output logic         click_seen
);
    track_t           cur;
    track_t           nxt;
    logic             pulse_d;
    logic             is_trans;
    logic [WIN_W-1:0] win;

    always_comb begin
        win      = window_len(win_sel);
        nxt      = cur;
        pulse_d  = 1'b0;
        is_trans = 1'b0;
        if (slice_tick) begin
            is_trans = ((cls == SLC_BLACK) && !cur.finger) ||
                       ((cls == SLC_WHITE) &&  cur.finger);
            if (is_trans) begin
                nxt.finger = (cls == SLC_BLACK);
                nxt.gap    = '0;
                if (cur.armed && (cur.gap < win)) begin
                    pulse_d   = 1'b1;
                    nxt.armed = 1'b0;
                end else begin
                    nxt.armed = 1'b1;
                end
            end else if (cur.armed && (cur.gap < win)) begin
                nxt.gap = cur.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= '0;
            click_pulse <= 1'b0;
            click_seen  <= 1'b0;
        end else if (!en) begin
            cur         <= '0;
            click_pulse <= 1'b0;
        end else begin
            cur         <= nxt;
            click_pulse <= pulse_d;
            click_seen  <= click_seen | pulse_d;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        click_pulse |=> !click_pulse); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        click_seen |=> click_seen); // R8
    AST_GAP_CAPPED: assert property (@(posedge clk) disable iff (rst)
        cur.gap <= win); // R6
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> !click_pulse); // R9

endmodule

// File: rtl/click_detect.sv
module click_detect
    import click_pkg::*;
#(
    parameter int BASE_DIV = 694444
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [11:0] pix,
    input  logic [1:0]  rate_sel,
    input  logic [1:0]  thr_sel,
    input  logic [2:0]  win_sel,
    output logic        click_pulse,
    output logic        click_seen
);
    click_cfg_t   cfg;
    logic         slice_tick;
    slice_class_t cls;

    assign cfg = '{rate: rate_sel, thr: thr_sel, win: win_sel};

    click_slice_timer #(.BASE_DIV(BASE_DIV)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .rate_sel   (cfg.rate),
        .slice_tick (slice_tick)
    );

    click_slice_classify u_classify (
        .pix     (pix),
        .thr_sel (cfg.thr),
        .cls     (cls)
    );

    click_pair_tracker u_tracker (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .slice_tick  (slice_tick),
        .cls         (cls),
        .win_sel     (cfg.win),
        .click_pulse (click_pulse),
        .click_seen  (click_seen)
    );

    AST_PULSE_ON_SLICE: assert property (@(posedge clk) disable iff (rst)
        click_pulse |-> $past(slice_tick)); // R2

endmodule

// File: tb/click_detect_tb.sv
module click_detect_tb;
    localparam int BD = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [11:0] pix = 12'h000;
    logic [1:0]  rate_sel = 2'd1;
    logic [1:0]  thr_sel = 2'd1;
    logic [2:0]  win_sel = 3'd5;
    logic        click_pulse;
    logic        click_seen;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    string cur_req = "R1";

    int m_cnt = 0, m_finger = 0, m_armed = 0, m_gap = 0, m_pulse = 0, m_seen = 0;

    always #4 clk = ~clk;

    click_detect #(.BASE_DIV(BD)) u_dut (
        .clk(clk), .rst(rst), .en(en), .pix(pix), .rate_sel(rate_sel),
        .thr_sel(thr_sel), .win_sel(win_sel),
        .click_pulse(click_pulse), .click_seen(click_seen)
    );

    function automatic int win_of(input int code);
        int t[8] = '{5, 7, 10, 12, 16, 20, 25, 31};
        return t[code];
    endfunction

    task automatic model_step();
        int ones, lim, w;
        bit blk, wht;
        if (rst) begin
            m_cnt = 0; m_finger = 0; m_armed = 0; m_gap = 0; m_pulse = 0; m_seen = 0;
        end else if (!en) begin
            m_cnt = 0; m_finger = 0; m_armed = 0; m_gap = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (m_cnt == BD * (int'(rate_sel) + 1) - 1) begin
                m_cnt = 0;
                ones = $countones(pix);
                lim = 7 + int'(thr_sel);
                w = win_of(int'(win_sel));
                blk = (ones > lim);
                wht = ((12 - ones) > lim);
                if ((blk && m_finger == 0) || (wht && m_finger == 1)) begin
                    if (m_armed == 1 && m_gap < w) begin
                        m_pulse = 1; m_seen = 1; m_armed = 0;
                    end else begin
                        m_armed = 1;
                    end
                    m_gap = 0;
                    m_finger = blk ? 1 : 0;
                end else if (m_armed == 1 && m_gap < w) begin
                    m_gap++;
                end
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            model_step();
            if (click_pulse) pulses++;
            check({cur_req, " pulse"}, int'(click_pulse), m_pulse);
            check({cur_req, " flag"}, int'(click_seen), m_seen);
        end
    endtask

    task automatic slices(input logic [11:0] p, input int n);
        pix = p;
        cyc(n * BD * (int'(rate_sel) + 1));
    endtask

    task automatic restart(input int r, input int t, input int w);
        en = 1'b0;
        cyc(2);
        rate_sel = 2'(r); thr_sel = 2'(t); win_sel = 3'(w);
        pix = 12'h000;
        en = 1'b1;
        pulses = 0;
    endtask

    initial begin
        cyc(3);
        check("R1 reset pulse", int'(click_pulse), 0);
        check("R1 reset flag", int'(click_seen), 0);
        rst = 1'b0;

        // R5 R10: default configuration, quick touch and release
        cur_req = "R5";
        restart(1, 1, 5);
        slices(12'h000, 2); slices(12'hFFF, 3); slices(12'h000, 1);
        check("R5 default click count", pulses, 1);
        check("R8 flag sticky", int'(click_seen), 1);

        // R6: gap equal to window gives no click, then new window
        cur_req = "R6";
        restart(0, 1, 0);
        slices(12'hFFF, 6); slices(12'h000, 1);
        check("R6 slow pair no click", pulses, 0);
        slices(12'hFFF, 1);
        check("R6 restart window click", pulses, 1);

        // R5: boundary gap of window minus one
        cur_req = "R5";
        restart(0, 1, 0);
        slices(12'hFFF, 5); slices(12'h000, 1);
        check("R5 gap 4 of 5 click", pulses, 1);

        // R3 R4: undecided slices under threshold code 3
        cur_req = "R3";
        restart(2, 3, 0);
        slices(12'hFFF, 1); slices(12'h3FF, 3); slices(12'h000, 1);
        check("R3 undecided no transition", pulses, 1);
        cur_req = "R4";
        restart(2, 3, 0);
        slices(12'hFFF, 1); slices(12'h3FF, 5); slices(12'h000, 1);
        check("R4 undecided counts gap", pulses, 0);

        // R3: threshold code 0 accepts 8 ones as black, 4 ones as white
        cur_req = "R3";
        restart(0, 0, 0);
        slices(12'h0FF, 1); slices(12'h00F, 1);
        check("R3 code0 click", pulses, 1);
        // R3: threshold code 2, 9 ones undecided
        restart(1, 2, 0);
        slices(12'h1FF, 1); slices(12'h000, 1);
        check("R3 code2 nine ones undecided", pulses, 0);

        // R7 R10: third transition cannot pair with second
        cur_req = "R7";
        restart(0, 1, 0);
        slices(12'hFFF, 1); slices(12'h000, 1); slices(12'hFFF, 1);
        check("R7 third transition no click", pulses, 1);
        slices(12'h000, 1);
        check("R7 fourth transition click", pulses, 2);
        check("R10 first black is transition", pulses, 2);

        // R9: enable low clears tracking, flag kept
        cur_req = "R9";
        restart(0, 1, 0);
        slices(12'hFFF, 1);
        en = 1'b0;
        cyc(5);
        en = 1'b1;
        slices(12'h000, 2);
        check("R9 no click across disable", pulses, 0);
        check("R9 flag retained", int'(click_seen), 1);

        // R2: slowest rate, long window
        cur_req = "R2";
        restart(3, 1, 7);
        slices(12'hFFF, 1); slices(12'h000, 1);
        check("R2 rate3 click", pulses, 1);

        // R1 R8: reset clears sticky flag
        cur_req = "R1";
        rst = 1'b1;
        cyc(2);
        check("R1 flag cleared by reset", int'(click_seen), 0);
        rst = 1'b0;
        cyc(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule